// File: doc/BRIEF.md
# Serial Receiver with Line Status Flags

This block turns an asynchronous serial input into characters of five to eight data bits. A start bit must still be low at its mid point before the frame is accepted. Each later bit is sampled once at its mid point, counted with an oversampling tick supplied from outside. The receiver checks optional even or odd parity and checks only the first stop bit. It recognises a break, meaning the line held low through the whole character. Finished characters go into a one-character holding buffer. Five status flags record data ready, overrun, parity error, framing error and break.

Software reads the buffer, the status register and an interrupt identification code using one-cycle read strobes. The flags, together with a holding-empty event and a modem-change level from neighbouring logic, feed a fixed-priority interrupt encoder. The encoder drives the identification code and a single request line.

Top module: `ser_rx_status`

## Requirements
- R1: Status bit 0 (data ready) goes high in the cycle after a character is stored and goes low after a `rd_buf` strobe, unless a new character is stored in that same cycle.
- R2: If a character completes while status bit 0 is still set, status bit 1 (overrun) is set and `rx_data` takes the newer character.
- R3: A `rd_lsr` strobe clears status bits 1 to 4. Bit 0 is not affected by it. Bit 5 follows `tx_hold_empty`, bit 6 follows `tx_shift_empty`, and bit 7 always reads 0.
- R4: With `cfg_par_en` high, one parity bit follows the data bits. Status bit 2 (parity error) is set when the data bits plus the parity bit have odd weight under even parity (`cfg_par_even`=1), or even weight under odd parity.
- R5: Only the first stop bit is sampled. If it is low, status bit 3 (framing error) is set and the receiver waits for the line to go high before it looks for a new start. A new start bit may follow a single high stop bit directly.
- R6: A character whose start, data, parity and stop samples are all low is a break. It sets status bits 4 and 3 and bit 0 but not bit 2, and stores 0x00.
- R7: A low pulse that has ended before the middle of the start bit (tick 8 of 16) is discarded and stores no character.
- R8: `iid` is 0x6 when line-status is enabled and any of status bits 1 to 4 is set. Otherwise it is 0x4 when receive is enabled and data is ready, then 0x2 for a pending holding-empty request, then 0x0 for an enabled modem change, and 0x1 when nothing is pending. `irq` is high unless `iid` is 0x1.
- R9: A holding-empty request becomes pending on a rising edge of `tx_hold_empty`. It is cleared by a `rd_iid` strobe while 0x2 is the code shown, or when `tx_hold_empty` falls.
- R10: `cfg_bits` 0,1,2,3 selects 5,6,7,8 data bits, received least significant first. The character appears right-aligned in `rx_data` with the unused upper bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Oversampling tick, 16 per bit time |
| rxd | input | 1 | Serial input, idle high |
| cfg_bits | input | 2 | Data bits per character minus 5 |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | 1 = even parity, 0 = odd |
| rd_buf | input | 1 | Read strobe for the receive buffer |
| rd_lsr | input | 1 | Read strobe for the status register |
| rd_iid | input | 1 | Read strobe for the identification code |
| ien_rx | input | 1 | Enable receive-data interrupt |
| ien_line | input | 1 | Enable line-status interrupt |
| ien_thre | input | 1 | Enable holding-empty interrupt |
| ien_modem | input | 1 | Enable modem-change interrupt |
| tx_hold_empty | input | 1 | Transmit holding stage empty |
| tx_shift_empty | input | 1 | Transmit shifter empty |
| modem_chg | input | 1 | Modem status change pending |
| rx_data | output | 8 | Receive buffer contents |
| lsr | output | 8 | Line status register |
| iid | output | 4 | Interrupt identification code |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach from the ports is several interrupt sources pending at once. For example, a line error, unread data and a fresh holding-empty edge can all be waiting while the encoder must still show the line code. The stimulus builds this up one step at a time. It leaves a character unread, sends a second one with a bad parity bit so that overrun and parity error appear together, and then raises the holding-empty input. After that it clears the sources in order with the status, buffer and identification strobes, and checks that each lower code appears in its turn. Break and framing recovery are driven the same way: the line is held low through whole characters, and a clean frame is then sent to confirm that the receiver recovered.

// File: rtl/ser_rx_pkg.sv
package ser_rx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP,
      ST_WAITHI
   } rx_st_t;

   typedef struct packed {
      logic [7:0] data;
      logic       perr;
      logic       ferr;
      logic       brk;
   } rx_frame_t;

   localparam logic [3:0] IID_LINE  = 4'h6;
   localparam logic [3:0] IID_RX    = 4'h4;
   localparam logic [3:0] IID_THRE  = 4'h2;
   localparam logic [3:0] IID_MODEM = 4'h0;
   localparam logic [3:0] IID_NONE  = 4'h1;

endpackage

// File: rtl/ser_rx_sync.sv
module ser_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign dout = din;
      end else begin : g_chain
         logic [STAGES-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '1;
            else if (STAGES == 1) q <= din;
            else q <= {q[STAGES-2:0], din};
         end
         assign dout = q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/ser_rx_frame.sv
module ser_rx_frame
   import ser_rx_pkg::*;
#(
   parameter int OSR = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       rx,
   input  logic [1:0] cfg_bits,
   input  logic       cfg_par_en,
   input  logic       cfg_par_even,
   output logic       done,
   output rx_frame_t  frame
);
   localparam int CW = $clog2(OSR);
   localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);
   localparam logic [CW-1:0] LAST = CW'(OSR - 1);

   generate
      if (OSR < 4 || (OSR % 2) != 0) begin : g_bad_osr
         $error("ser_rx_frame: OSR must be even and at least 4");
      end
   endgenerate

   rx_st_t        st;
   logic [CW-1:0] cnt;
   logic [2:0]    bitn;
   logic [7:0]    acc;
   logic          par;
   logic          anyhi;

   logic [2:0] last_bit;
   logic [1:0] shamt;
   logic       is_brk;
   assign last_bit = 3'd4 + {1'b0, cfg_bits};
   assign shamt    = 2'd3 - cfg_bits;
   assign is_brk   = !rx && !anyhi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= ST_IDLE;
         cnt   <= '0;
         bitn  <= '0;
         acc   <= '0;
         par   <= 1'b0;
         anyhi <= 1'b0;
         done  <= 1'b0;
         frame <= '0;
      end else begin
         done <= 1'b0;
         if (tick) begin
            unique case (st)
               ST_IDLE: begin
                  if (!rx) begin
                     st  <= ST_START;
                     cnt <= '0;
                  end
               end
               ST_START: begin
                  if (cnt == MID) begin
                     cnt <= '0;
                     if (!rx) begin
                        st    <= ST_DATA;
                        bitn  <= '0;
                        acc   <= '0;
                        par   <= 1'b0;
                        anyhi <= 1'b0;
                     end else begin
                        st <= ST_IDLE;
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_DATA: begin
                  if (cnt == LAST) begin
                     cnt   <= '0;
                     acc   <= {rx, acc[7:1]};
                     par   <= par ^ rx;
                     anyhi <= anyhi | rx;
                     if (bitn == last_bit) st <= cfg_par_en ? ST_PAR : ST_STOP;
                     else bitn <= bitn + 1'b1;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_PAR: begin
                  if (cnt == LAST) begin
                     cnt   <= '0;
                     par   <= par ^ rx;
                     anyhi <= anyhi | rx;
                     st    <= ST_STOP;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_STOP: begin
                  if (cnt == LAST) begin
                     cnt        <= '0;
                     done       <= 1'b1;
                     frame.data <= is_brk ? 8'h00 : (acc >> shamt);
                     frame.ferr <= !rx;
                     frame.brk  <= is_brk;
                     frame.perr <= cfg_par_en && !is_brk && (par ^ !cfg_par_even);
                     st         <= rx ? ST_IDLE : ST_WAITHI;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_WAITHI: begin
                  if (rx) st <= ST_IDLE;
               end
               default: st <= ST_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/ser_rx_flags.sv
module ser_rx_flags
   import ser_rx_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       done,
   input  rx_frame_t  frame,
   input  logic       rd_buf,
   input  logic       rd_lsr,
   input  logic       tx_hold_empty,
   input  logic       tx_shift_empty,
   output logic [7:0] rx_data,
   output logic [7:0] lsr
);
   logic [7:0] buf_q;
   logic dr, oe, pe, fe, bi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_q <= '0;
         dr    <= 1'b0;
         oe    <= 1'b0;
         pe    <= 1'b0;
         fe    <= 1'b0;
         bi    <= 1'b0;
      end else begin
         if (done) buf_q <= frame.data;
         dr <= done | (dr & ~rd_buf);
         oe <= (oe & ~rd_lsr) | (done & dr & ~rd_buf);
         pe <= (pe & ~rd_lsr) | (done & frame.perr);
         fe <= (fe & ~rd_lsr) | (done & frame.ferr);
         bi <= (bi & ~rd_lsr) | (done & frame.brk);
      end
   end

   assign rx_data = buf_q;
   assign lsr     = {1'b0, tx_shift_empty, tx_hold_empty, bi, fe, pe, oe, dr};
endmodule

// File: rtl/ser_rx_irq.sv
module ser_rx_irq
   import ser_rx_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [4:0] flags,
   input  logic       ien_rx,
   input  logic       ien_line,
   input  logic       ien_thre,
   input  logic       ien_modem,
   input  logic       tx_hold_empty,
   input  logic       modem_chg,
   input  logic       rd_iid,
   output logic [3:0] iid,
   output logic       irq
);
   logic prev_he;
   logic thre_req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_he  <= 1'b1;
         thre_req <= 1'b0;
      end else begin
         prev_he <= tx_hold_empty;
         if (tx_hold_empty && !prev_he) thre_req <= 1'b1;
         else if (!tx_hold_empty) thre_req <= 1'b0;
         else if (rd_iid && iid == IID_THRE) thre_req <= 1'b0;
      end
   end

   always_comb begin
      if (ien_line && (flags[4:1] != 4'b0))  iid = IID_LINE;
      else if (ien_rx && flags[0])           iid = IID_RX;
      else if (ien_thre && thre_req)         iid = IID_THRE;
      else if (ien_modem && modem_chg)       iid = IID_MODEM;
      else                                   iid = IID_NONE;
   end

   assign irq = (iid != IID_NONE);
endmodule

// File: rtl/ser_rx_status.sv
module ser_rx_status
   import ser_rx_pkg::*;
#(
   parameter int OSR         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick16,
   input  logic       rxd,
   input  logic [1:0] cfg_bits,
   input  logic       cfg_par_en,
   input  logic       cfg_par_even,
   input  logic       rd_buf,
   input  logic       rd_lsr,
   input  logic       rd_iid,
   input  logic       ien_rx,
   input  logic       ien_line,
   input  logic       ien_thre,
   input  logic       ien_modem,
   input  logic       tx_hold_empty,
   input  logic       tx_shift_empty,
   input  logic       modem_chg,
   output logic [7:0] rx_data,
   output logic [7:0] lsr,
   output logic [3:0] iid,
   output logic       irq
);
   generate
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("ser_rx_status: SYNC_STAGES must be 0 to 4");
      end
   endgenerate

   logic      rx_s;
   logic      fr_done;
   rx_frame_t fr;

   ser_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rx_s)
   );

   ser_rx_frame #(.OSR(OSR)) u_frame (
      .clk(clk), .rst_n(rst_n), .tick(tick16), .rx(rx_s),
      .cfg_bits(cfg_bits), .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
      .done(fr_done), .frame(fr)
   );

   ser_rx_flags u_flags (
      .clk(clk), .rst_n(rst_n), .done(fr_done), .frame(fr),
      .rd_buf(rd_buf), .rd_lsr(rd_lsr),
      .tx_hold_empty(tx_hold_empty), .tx_shift_empty(tx_shift_empty),
      .rx_data(rx_data), .lsr(lsr)
   );

   ser_rx_irq u_irq (
      .clk(clk), .rst_n(rst_n), .flags(lsr[4:0]),
      .ien_rx(ien_rx), .ien_line(ien_line), .ien_thre(ien_thre), .ien_modem(ien_modem),
      .tx_hold_empty(tx_hold_empty), .modem_chg(modem_chg), .rd_iid(rd_iid),
      .iid(iid), .irq(irq)
   );
endmodule

// File: rtl/ser_rx_chk.sv
module ser_rx_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       done,
   input logic       brk,
   input logic       rd_buf,
   input logic       rd_lsr,
   input logic       ien_rx,
   input logic       ien_line,
   input logic [7:0] lsr,
   input logic [7:0] rx_data,
   input logic [3:0] iid
);
   AST_DR_SET:   assert property (@(posedge clk) disable iff (!rst_n) done |=> lsr[0]); // R1
   AST_DR_CLR:   assert property (@(posedge clk) disable iff (!rst_n) (rd_buf && !done) |=> !lsr[0]); // R1
   AST_OVERRUN:  assert property (@(posedge clk) disable iff (!rst_n) (done && lsr[0] && !rd_buf) |=> lsr[1]); // R2
   AST_ERR_CLR:  assert property (@(posedge clk) disable iff (!rst_n) (rd_lsr && !done) |=> (lsr[4:1] == 4'b0)); // R3
   AST_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n) lsr[7] == 1'b0); // R3
   AST_BRK_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (done && brk) |=> (rx_data == 8'h00 && lsr[4] && !lsr[2])); // R6
   AST_LINE_TOP: assert property (@(posedge clk) disable iff (!rst_n) (ien_line && lsr[4:1] != 4'b0) |-> iid == 4'h6); // R8
   AST_RX_NEXT:  assert property (@(posedge clk) disable iff (!rst_n)
                    (ien_rx && lsr[0] && !(ien_line && lsr[4:1] != 4'b0)) |-> iid == 4'h4); // R8
endmodule

bind ser_rx_status ser_rx_chk u_chk (
   .clk(clk), .rst_n(rst_n), .done(fr_done), .brk(fr.brk),
   .rd_buf(rd_buf), .rd_lsr(rd_lsr), .ien_rx(ien_rx), .ien_line(ien_line),
   .lsr(lsr), .rx_data(rx_data), .iid(iid)
);

// File: tb/sim_ser_rx_status.sv
`timescale 1ns/1ps
module sim_ser_rx_status;
   localparam int TDIV = 2;
   localparam int BITC = 16 * TDIV;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick16 = 1'b0;
   logic rxd = 1'b1;
   logic [1:0] cfg_bits = 2'd3;
   logic cfg_par_en = 1'b0, cfg_par_even = 1'b1;
   logic rd_buf = 1'b0, rd_lsr = 1'b0, rd_iid = 1'b0;
   logic ien_rx = 1'b0, ien_line = 1'b0, ien_thre = 1'b0, ien_modem = 1'b0;
   logic tx_hold_empty = 1'b1, tx_shift_empty = 1'b1, modem_chg = 1'b0;
   logic [7:0] rx_data, lsr;
   logic [3:0] iid;
   logic irq;

   int total = 0;
   int bad = 0;
   bit finished = 0;
   int tcnt = 0;

   always #4 clk = ~clk;

   always @(posedge clk) begin
      tcnt   <= (tcnt == TDIV - 1) ? 0 : tcnt + 1;
      tick16 <= (tcnt == TDIV - 1);
   end

   ser_rx_status u0 (
      .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
      .cfg_bits(cfg_bits), .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
      .rd_buf(rd_buf), .rd_lsr(rd_lsr), .rd_iid(rd_iid),
      .ien_rx(ien_rx), .ien_line(ien_line), .ien_thre(ien_thre), .ien_modem(ien_modem),
      .tx_hold_empty(tx_hold_empty), .tx_shift_empty(tx_shift_empty), .modem_chg(modem_chg),
      .rx_data(rx_data), .lsr(lsr), .iid(iid), .irq(irq)
   );

   task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%02h expected=%02h", req, what, act, exp);
      end
   endtask

   task automatic line_bit(input logic b);
      rxd = b;
      repeat (BITC) @(negedge clk);
   endtask

   task automatic send(input logic [7:0] d, input int nb, input logic pen, input logic peven,
                       input logic flip, input logic stopv, input int idle);
      logic p;
      p = 1'b0;
      cfg_bits = 2'(nb - 5);
      cfg_par_en = pen;
      cfg_par_even = peven;
      line_bit(1'b0);
      for (int i = 0; i < nb; i++) begin
         line_bit(d[i]);
         p = p ^ d[i];
      end
      if (pen) line_bit((peven ? p : ~p) ^ flip);
      line_bit(stopv);
      rxd = 1'b1;
      repeat (idle * BITC) @(negedge clk);
   endtask

   task automatic strobe(input int which);
      if (which == 0) rd_buf = 1'b1;
      else if (which == 1) rd_lsr = 1'b1;
      else rd_iid = 1'b1;
      @(negedge clk);
      rd_buf = 1'b0; rd_lsr = 1'b0; rd_iid = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_reset;
      chk("R3", "lsr after reset", lsr, 8'h60);
      chk("R8", "iid after reset", {4'h0, iid}, 8'h01);
      chk("R8", "irq after reset", {7'h0, irq}, 8'h00);
      chk("R1", "rx_data after reset", rx_data, 8'h00);
   endtask

   task automatic t_basic;
      send(8'hA5, 8, 1'b0, 1'b1, 1'b0, 1'b1, 1);
      chk("R1", "data ready set", lsr, 8'h61);
      chk("R10", "8-bit data", rx_data, 8'hA5);
      strobe(1);
      chk("R3", "lsr read keeps data ready", lsr, 8'h61);
      strobe(0);
      chk("R1", "data ready cleared by read", lsr, 8'h60);
   endtask

   task automatic t_wordlen;
      send(8'hF3, 5, 1'b0, 1'b1, 1'b0, 1'b1, 1);
      chk("R10", "5-bit data", rx_data, 8'h13);
      strobe(0);
      send(8'hEC, 6, 1'b0, 1'b1, 1'b0, 1'b1, 1);
      chk("R10", "6-bit data", rx_data, 8'h2C);
      strobe(0);
      send(8'hDA, 7, 1'b0, 1'b1, 1'b0, 1'b1, 1);
      chk("R10", "7-bit data", rx_data, 8'h5A);
      strobe(0);
   endtask

   task automatic t_parity;
      send(8'h3C, 8, 1'b1, 1'b1, 1'b0, 1'b1, 1);
      chk("R4", "even parity ok", lsr, 8'h61);
      strobe(0);
      send(8'h3D, 8, 1'b1, 1'b0, 1'b0, 1'b1, 1);
      chk("R4", "odd parity ok", lsr, 8'h61);
      chk("R4", "odd parity data", rx_data, 8'h3D);
      strobe(0);
      send(8'h5B, 7, 1'b1, 1'b1, 1'b1, 1'b1, 1);
      chk("R4", "even parity error", lsr, 8'h65);
      strobe(1);
      chk("R3", "parity flag cleared by lsr read", lsr, 8'h61);
      strobe(0);
      cfg_par_en = 1'b0;
      cfg_bits = 2'd3;
   endtask

   task automatic t_overrun;
      send(8'h11, 8, 1'b0, 1'b1, 1'b0, 1'b1, 0);
      send(8'h22, 8, 1'b0, 1'b1, 1'b0, 1'b1, 1);
      chk("R2", "overrun flag", lsr, 8'h63);
      chk("R2", "newer character kept", rx_data, 8'h22);
      chk("R5", "start right after one stop bit", rx_data, 8'h22);
      strobe(1);
      chk("R3", "overrun cleared", lsr, 8'h61);
      strobe(0);
   endtask

   task automatic t_framing;
      send(8'h55, 8, 1'b0, 1'b1, 1'b0, 1'b0, 1);
      chk("R5", "framing flag", lsr, 8'h69);
      chk("R5", "data with framing error", rx_data, 8'h55);
      strobe(1);
      strobe(0);
      send(8'h77, 8, 1'b0, 1'b1, 1'b0, 1'b1, 1);
      chk("R5", "resync status", lsr, 8'h61);
      chk("R5", "resync data", rx_data, 8'h77);
      strobe(0);
   endtask

   task automatic t_break;
      rxd = 1'b0;
      repeat (12 * BITC) @(negedge clk);
      rxd = 1'b1;
      repeat (2 * BITC) @(negedge clk);
      chk("R6", "break status", lsr, 8'h79);
      chk("R6", "break stores zero", rx_data, 8'h00);
      strobe(1);
      chk("R6", "break flags cleared", lsr, 8'h61);
      strobe(0);
      chk("R6", "single character per break", lsr, 8'h60);
   endtask

   task automatic t_glitch;
      rxd = 1'b0;
      repeat (8) @(negedge clk);
      rxd = 1'b1;
      repeat (3 * BITC) @(negedge clk);
      chk("R7", "short low pulse discarded", lsr, 8'h60);
      send(8'h81, 8, 1'b0, 1'b1, 1'b0, 1'b1, 1);
      chk("R7", "frame after glitch", rx_data, 8'h81);
      strobe(0);
   endtask

   task automatic t_irq;
      ien_rx = 1'b1; ien_line = 1'b1; ien_thre = 1'b1; ien_modem = 1'b1;
      @(negedge clk);
      chk("R8", "nothing pending", {4'h0, iid}, 8'h01);
      tx_hold_empty = 1'b0;
      @(negedge clk);
      tx_hold_empty = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk("R9", "holding-empty pending", {4'h0, iid}, 8'h02);
      chk("R9", "irq raised", {7'h0, irq}, 8'h01);
      strobe(2);
      chk("R9", "iid read clears holding-empty", {4'h0, iid}, 8'h01);
      send(8'h42, 8, 1'b0, 1'b1, 1'b0, 1'b1, 1);
      chk("R8", "received data code", {4'h0, iid}, 8'h04);
      send(8'h43, 8, 1'b1, 1'b1, 1'b1, 1'b1, 1);
      cfg_par_en = 1'b0;
      chk("R8", "line code with overrun and parity", {4'h0, iid}, 8'h06);
      tx_hold_empty = 1'b0;
      @(negedge clk);
      tx_hold_empty = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk("R8", "line above holding-empty", {4'h0, iid}, 8'h06);
      strobe(1);
      chk("R8", "rx above holding-empty", {4'h0, iid}, 8'h04);
      strobe(0);
      chk("R8", "holding-empty surfaces", {4'h0, iid}, 8'h02);
      strobe(2);
      modem_chg = 1'b1;
      @(negedge clk);
      chk("R8", "modem code", {4'h0, iid}, 8'h00);
      chk("R8", "irq for modem", {7'h0, irq}, 8'h01);
      modem_chg = 1'b0;
      tx_shift_empty = 1'b0;
      @(negedge clk);
      chk("R8", "idle code", {4'h0, iid}, 8'h01);
      chk("R3", "shift-empty bit follows input", lsr, 8'h20);
      tx_shift_empty = 1'b1;
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      t_reset();
      t_basic();
      t_wordlen();
      t_parity();
      t_overrun();
      t_framing();
      t_break();
      t_glitch();
      t_irq();
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule